// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Register

This block guards a processor against hangs. Software starts it through one 8-bit control/status register. It then has to keep clearing it before a small counter, advanced by one of four prescaled tick taps, runs past its top value. If the counter does run past its top value, the block drives a reset request for one clock. It also records that the last reset came from the watchdog.

The same register shows which of four sources caused the most recent reset: power-on, watchdog, external pin or software. Once the watchdog is started, software cannot stop it, and neither can a sleep or timebase mode, nor an external or software reset. Those events only restart the count, or hold it at zero. Only power-on or the watchdog's own expiry return it to the stopped state.

The power-on reset is the block's own synchronous active-low reset `rst_n`. External and software resets arrive as one-cycle indications from the reset sequencer. The tick taps are one-cycle strobes from an external prescaler.

Top module: `wdt_guard`

## Requirements
- R1: After power-on reset (`rst_n` low at a clock edge) the register reads 8'h84, `bite_o` is low and the watchdog is stopped.
- R2: Register read layout: bit7 = power-on cause, bit6 = 0, bit5 = watchdog cause, bit4 = external cause, bit3 = software cause, bit2 = always 1, bits 1:0 = interval select.
- R3: A write with bit2 = 0 while stopped starts the watchdog with the count at 0. A write with bit2 = 1 never starts it.
- R4: While running, the counter advances on `tap_tick_i[sel]`, where sel is the interval field. It overflows on the 4th selected tick after a clear. `bite_o` is high for exactly one clock, in the cycle after the edge that samples that tick. Ticks on the other taps are ignored.
- R5: A write with bit2 = 0 while running clears the count. The watchdog keeps running.
- R6: A write while stopped loads bits 1:0 into the interval field. A write while running leaves the interval unchanged.
- R7: An external or software reset indication sets its own cause flag and clears the other three. It clears the count and leaves a running watchdog running. If both arrive in the same cycle, the external flag wins.
- R8: A sleep-entry strobe clears the count. It leaves the running state and the cause flags unchanged.
- R9: While `tbase_mode_i` is high, the count is held at 0 and no ticks are counted. The watchdog stays started, and counting resumes from 0 when the mode ends.
- R10: On overflow, the watchdog cause flag is set, the other cause flags are cleared and the watchdog stops. The interval is kept, and a new write with bit2 = 0 is needed to restart it.
- R11: Any clearing event (R5, R7, R8, R9) in the same cycle as a would-be overflow tick cancels the overflow and leaves the count at 0.
- R12: Power-on reset stops a running watchdog, sets the interval to 00 and leaves only the power-on cause flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| ext_rst_i | input | 1 | One-cycle indication of an external reset |
| sw_rst_i | input | 1 | One-cycle indication of a software reset |
| sleep_enter_i | input | 1 | One-cycle strobe on entry to sleep mode |
| tbase_mode_i | input | 1 | High while in timebase timer mode |
| tap_tick_i | input | 4 | One-cycle tick strobes from the four prescaler taps |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| bite_o | output | 1 | One-clock watchdog reset request |

## Verification
The bench targets a clear arriving on the very cycle of the fourth tick. A design that tested overflow before the clear would bite there even though software serviced it in time. It also checks writes made while running and an external reset during a run. A design that let those writes retarget the interval, or let the reset drop the started state, would give a lock that software could defeat. Timebase mode is held across many ticks: a design that stopped outright would never bite afterwards, and one that only cleared once would bite during the mode. A design that latched the expiry pulse or kept running after expiry shows up as repeated or stretched `bite_o` pulses, and ext/sw collisions catch a wrong cause priority.

// File: rtl/wdt_guard_pkg.sv
// Shared constants, types and read-data packing for the watchdog.
// Assumes the fixed 8-bit register layout described in the brief.
package wdt_guard_pkg;
    localparam int REG_W    = 8;
    localparam int IV_W     = 2;
    localparam int NUM_TAPS = 1 << IV_W;

    localparam int BIT_POR = 7;
    localparam int BIT_RSV = 6;
    localparam int BIT_WD  = 5;
    localparam int BIT_EXT = 4;
    localparam int BIT_SW  = 3;
    localparam int BIT_EN  = 2;

    // Cause flags, one per reset source
    typedef struct packed {
        logic por;
        logic wd;
        logic ext;
        logic sw;
    } cause_t;

    localparam cause_t CAUSE_POR = '{por: 1'b1, wd: 1'b0, ext: 1'b0, sw: 1'b0};
    localparam cause_t CAUSE_WD  = '{por: 1'b0, wd: 1'b1, ext: 1'b0, sw: 1'b0};
    localparam cause_t CAUSE_EXT = '{por: 1'b0, wd: 1'b0, ext: 1'b1, sw: 1'b0};
    localparam cause_t CAUSE_SW  = '{por: 1'b0, wd: 1'b0, ext: 1'b0, sw: 1'b1};

    // Build the readable register image from flags and interval
    function automatic logic [REG_W-1:0] pack_status(cause_t c, logic [IV_W-1:0] iv);
        logic [REG_W-1:0] r;
        r             = '0;
        r[BIT_POR]    = c.por;
        r[BIT_RSV]    = 1'b0;
        r[BIT_WD]     = c.wd;
        r[BIT_EXT]    = c.ext;
        r[BIT_SW]     = c.sw;
        r[BIT_EN]     = 1'b1;
        r[IV_W-1:0]   = iv;
        return r;
    endfunction
endpackage

// File: rtl/wdt_tap_sel.sv
// Selects one prescaler tick tap by index.
// Assumes taps are one-cycle strobes; the output is purely combinational.
module wdt_tap_sel #(
    parameter int N     = 4,
    parameter int SEL_W = $clog2(N)
) (
    input  logic [N-1:0]     taps_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    logic [N-1:0] hit;

    // One AND term per tap, ORed into the selected tick
    for (genvar i = 0; i < N; i++) begin : g_tap
        assign hit[i] = taps_i[i] && (sel_i == SEL_W'(i));
    end

    assign tick_o = |hit;
endmodule

// File: rtl/wdt_counter.sv
// Timeout counter: counts selected ticks while running and flags overflow
// on the tick that would carry past the all-ones value. A clear always
// wins over a tick in the same cycle. Assumes run_i comes from a register.
module wdt_counter #(
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic clr_i,
    output logic ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Overflow when the last step is taken without a competing clear
    assign ovf_o = run_i && tick_i && !clr_i && (cnt_q == CNT_MAX);

    // Count register: zero when stopped or cleared, else step on tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !clr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i && !clr_i) |=> $stable(cnt_q)); // R4
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> !ovf_o); // R11
endmodule

// File: rtl/wdt_status.sv
// Control/status state: started flag, interval field, cause flags and
// the registered one-clock bite pulse. Power-on is the block reset.
// Assumes overflow is only raised while started.
module wdt_status
    import wdt_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rst_i,
    input  logic             sw_rst_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             ovf_i,
    output logic             run_o,
    output logic [IV_W-1:0]  iv_o,
    output logic [REG_W-1:0] rd_data_o,
    output logic             bite_o
);
    cause_t cause_q;
    logic   start_req;

    // A write of 0 to the enable bit while stopped is a start request
    assign start_req = wr_en_i && !wr_data_i[BIT_EN] && !run_o;

    // Started flag: set by a start request, dropped only by overflow or power-on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o <= 1'b0;
        end else if (ovf_i) begin
            run_o <= 1'b0;
        end else if (start_req) begin
            run_o <= 1'b1;
        end
    end

    // Interval field: writable only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv_o <= '0;
        end else if (wr_en_i && !run_o) begin
            iv_o <= wr_data_i[IV_W-1:0];
        end
    end

    // Cause flags: latest source wins, watchdog then external then software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CAUSE_POR;
        end else if (ovf_i) begin
            cause_q <= CAUSE_WD;
        end else if (ext_rst_i) begin
            cause_q <= CAUSE_EXT;
        end else if (sw_rst_i) begin
            cause_q <= CAUSE_SW;
        end
    end

    // Bite pulse: one clock after the overflowing tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bite_o <= 1'b0;
        end else begin
            bite_o <= ovf_i;
        end
    end

    // Register read image
    assign rd_data_o = pack_status(cause_q, iv_o);

    AST_BITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bite_o |=> !bite_o); // R4
    AST_BITE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        bite_o |-> (!run_o && cause_q == CAUSE_WD)); // R10
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !ovf_i) |=> run_o); // R7
    AST_IV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |=> $stable(iv_o)); // R6
    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cause_q) == 1); // R2
endmodule

// File: rtl/wdt_guard.sv
// Watchdog top: joins tap selection, timeout counter and status register.
// Assumes all strobes are synchronous to clk and one cycle wide.
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_rst_i,
    input  logic                sw_rst_i,
    input  logic                sleep_enter_i,
    input  logic                tbase_mode_i,
    input  logic [NUM_TAPS-1:0] tap_tick_i,
    input  logic                wr_en_i,
    input  logic [REG_W-1:0]    wr_data_i,
    output logic [REG_W-1:0]    rd_data_o,
    output logic                bite_o
);
    logic            run;
    logic [IV_W-1:0] iv;
    logic            tick;
    logic            clr;
    logic            ovf;

    // Any event that restarts the count without stopping the watchdog
    assign clr = ext_rst_i || sw_rst_i || sleep_enter_i || tbase_mode_i
              || (wr_en_i && !wr_data_i[BIT_EN] && run);

    wdt_tap_sel #(
        .N     (NUM_TAPS),
        .SEL_W (IV_W)
    ) u_sel (
        .taps_i (tap_tick_i),
        .sel_i  (iv),
        .tick_o (tick)
    );

    wdt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_i (tick),
        .clr_i  (clr),
        .ovf_o  (ovf)
    );

    wdt_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_rst_i (ext_rst_i),
        .sw_rst_i  (sw_rst_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .ovf_i     (ovf),
        .run_o     (run),
        .iv_o      (iv),
        .rd_data_o (rd_data_o),
        .bite_o    (bite_o)
    );

    AST_TBASE_NO_BITE: assert property (@(posedge clk) disable iff (!rst_n)
        tbase_mode_i |=> !bite_o); // R9
    AST_EXT_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst_i && run) |=> run); // R7
    AST_SLEEP_KEEPS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_enter_i && !ext_rst_i && !sw_rst_i) |=> $stable(rd_data_o[7:3])); // R8
endmodule

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random stimulus,
// all compared each cycle against a bench-side reference model.
module wdt_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext = 1'b0, sw = 1'b0, slp = 1'b0, tb = 1'b0, wr = 1'b0;
    logic [3:0] taps = '0;
    logic [7:0] wd = '0;
    logic [7:0] rd_data_o;
    logic       bite_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    wdt_guard uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_rst_i     (ext),
        .sw_rst_i      (sw),
        .sleep_enter_i (slp),
        .tbase_mode_i  (tb),
        .tap_tick_i    (taps),
        .wr_en_i       (wr),
        .wr_data_i     (wd),
        .rd_data_o     (rd_data_o),
        .bite_o        (bite_o)
    );

    typedef struct packed {
        logic       run;
        logic [1:0] cnt;
        logic [1:0] iv;
        logic       por, wdf, exf, swf;
        logic       bite;
    } mstate_t;

    mstate_t ms;

    // Reference next state from the requirements
    function automatic mstate_t model_next(mstate_t s, logic r_n, logic e, logic so,
                                           logic sl, logic t, logic [3:0] tp,
                                           logic w, logic [7:0] d);
        mstate_t n;
        logic    clr;
        n = s;
        n.bite = 1'b0;
        if (!r_n) begin
            n = '0;
            n.por = 1'b1;
            return n;
        end
        clr = e || so || sl || t || (w && !d[2] && s.run);
        if (w && !s.run) n.iv = d[1:0];
        if (w && !d[2] && !s.run) begin
            n.run = 1'b1;
            n.cnt = 2'd0;
        end
        if (clr) begin
            n.cnt = 2'd0;
        end else if (s.run && tp[s.iv]) begin
            if (s.cnt == 2'd3) begin
                n.bite = 1'b1;
                n.run  = 1'b0;
                n.cnt  = 2'd0;
                {n.por, n.wdf, n.exf, n.swf} = 4'b0100;
            end else begin
                n.cnt = s.cnt + 2'd1;
            end
        end
        if (e)       {n.por, n.wdf, n.exf, n.swf} = 4'b0010;
        else if (so) {n.por, n.wdf, n.exf, n.swf} = 4'b0001;
        return n;
    endfunction

    // Expected register image: {por,0,wd,ext,sw,1,iv}
    function automatic logic [7:0] model_reg(mstate_t s);
        return {s.por, 1'b0, s.wdf, s.exf, s.swf, 1'b1, s.iv};
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s rd_data actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s bite actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: model update, compare both outputs, drop strobes
    task automatic step(input string tag);
        mstate_t nx;
        nx = model_next(ms, rst_n, ext, sw, slp, tb, taps, wr, wd);
        @(posedge clk);
        #2;
        ms = nx;
        check8(tag, rd_data_o, model_reg(ms));
        check1(tag, bite_o, ms.bite);
        ext = 1'b0; sw = 1'b0; slp = 1'b0; wr = 1'b0; taps = '0;
    endtask

    task automatic ticks(input logic [3:0] mask, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            taps = mask;
            step(tag);
        end
    endtask

    task automatic write(input logic [7:0] d, input string tag);
        wr = 1'b1; wd = d;
        step(tag);
    endtask

    // Watchdog on the bench itself
    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        ms = '0;
        ms.por = 1'b1;
        rst_n = 1'b0;
        step("R1 reset");
        step("R1 reset");
        rst_n = 1'b1;
        step("R1 idle");
        check8("R1 value", rd_data_o, 8'h84);
        check1("R1 no bite", bite_o, 1'b0);

        write(8'hFF, "R3 bit2=1");
        check8("R2 iv readback", rd_data_o, 8'h87);
        ticks(4'hF, 6, "R3 not started");
        check1("R3 no bite", bite_o, 1'b0);

        write(8'h02, "R3 start");
        write(8'h01, "R6 locked");
        check8("R6 iv kept", rd_data_o, 8'h86);
        ticks(4'b0100, 3, "R4 count");
        write(8'h00, "R5 clear");
        ticks(4'b1011, 5, "R4 other taps");
        ticks(4'b0100, 3, "R5 after clear");
        check1("R5 no early bite", bite_o, 1'b0);
        ticks(4'b0100, 1, "R4 overflow");
        check1("R4 bite", bite_o, 1'b1);
        check8("R10 cause", rd_data_o, 8'h26);
        step("R4 one clock");
        check1("R4 pulse ends", bite_o, 1'b0);
        ticks(4'b0100, 6, "R10 stopped");

        write(8'h00, "R3 restart");
        ticks(4'b0001, 3, "R7 pre");
        ext = 1'b1; step("R7 ext");
        check8("R7 ext flag", rd_data_o, 8'h14);
        ticks(4'b0001, 3, "R7 still running");
        ticks(4'b0001, 1, "R7 bite");
        check1("R7 bite after ext", bite_o, 1'b1);

        write(8'h00, "R3 restart");
        ticks(4'b0001, 2, "R7 pre");
        ext = 1'b1; sw = 1'b1; step("R7 both");
        check8("R7 ext wins", rd_data_o, 8'h14);
        sw = 1'b1; step("R7 sw");
        check8("R7 sw flag", rd_data_o, 8'h0C);

        ticks(4'b0001, 3, "R8 pre");
        slp = 1'b1; step("R8 sleep");
        check8("R8 flags kept", rd_data_o, 8'h0C);
        ticks(4'b0001, 3, "R8 no bite");
        ticks(4'b0001, 1, "R8 bite");
        check1("R8 bite", bite_o, 1'b1);

        write(8'h00, "R3 restart");
        ticks(4'b0001, 3, "R9 pre");
        tb = 1'b1;
        ticks(4'b0001, 10, "R9 held");
        tb = 1'b0;
        ticks(4'b0001, 3, "R9 resume");
        check1("R9 no bite yet", bite_o, 1'b0);
        ticks(4'b0001, 1, "R9 bite");
        check1("R9 bite", bite_o, 1'b1);

        write(8'h00, "R3 restart");
        ticks(4'b0001, 3, "R11 pre");
        taps = 4'b0001; slp = 1'b1; step("R11 clash");
        check1("R11 cancelled", bite_o, 1'b0);
        taps = 4'b0001; wr = 1'b1; wd = 8'h00;
        ticks(4'b0001, 3, "R11 after");
        check1("R11 still none", bite_o, 1'b0);

        write(8'h03, "R12 prep");
        rst_n = 1'b0; step("R12 por");
        rst_n = 1'b1;
        check8("R12 value", rd_data_o, 8'h84);
        ticks(4'hF, 8, "R12 stopped");

        // Seeded random phase
        void'($urandom(32'h5EED_0042));
        for (int c = 0; c < 6000; c++) begin
            taps  = 4'($urandom);
            ext   = ($urandom % 64) == 0;
            sw    = ($urandom % 64) == 0;
            slp   = ($urandom % 40) == 0;
            if (($urandom % 50) == 0) tb = ~tb;
            wr    = ($urandom % 16) == 0;
            wd    = 8'($urandom);
            rst_n = ($urandom % 700) != 0;
            step("R4/R7 random");
        end
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule